// File: doc/BRIEF.md
# Set/Clear Interrupt Enable Controller

This block holds the enable state for a set of interrupt sources. Software reaches it over a simple register bus with one-cycle read and write strobes. The state lives in a small bank of mask registers and priority registers. Mask registers are updated only through a pair of addresses: one alias ORs bits in and the other knocks bits out. Priority registers are overwritten whole, and each one is split into equal fields. A source can be named in several places: mask bits, priority fields, and group entries. A group entry fans its enable change out to every member source.

For each source the block keeps a counter of how many of its enabling conditions currently hold. It raises that source's enable output only when the counter reaches the number of places the source is named. Each write is compared field by field against the stored value, and only fields that change adjust a counter. Which sources exist, where each is mapped and which groups contain it are all fixed by parameters.

Top module: `irq_enable_ctrl`

## Requirements
- R1: Address decode compares only bits 28:0 of `addr` with each configured register address, so bits 31:29 have no effect. A configured address of zero never matches. A write that matches nothing changes no state, and a read that matches nothing returns 0.
- R2: A write to a mask register's set alias ORs `wdata` into the stored value.
- R3: A write to a mask register's clear alias clears every stored bit that is 1 in `wdata`.
- R4: A write to a priority register's address replaces its stored value with the low PREG_W bits of `wdata`. A mask register whose clear address is zero ignores writes.
- R5: A read returns, in the cycle after `rd_en`, the stored value of the addressed register, zero-extended to 32 bits. Either alias of a mask register returns the same value.
- R6: Mask bit MREG_W-1 maps to the first source of the register, and each lower bit maps to the next source. Priority fields map the same way, highest field first. A priority field enables its source when it is nonzero. Default map: mask register 0 (set 0x100, clear 0x104) holds ids 1,2,3,12,0,11,8,5 from bit 7 down to bit 0. Mask register 1 (0x108 and 0x10C) holds 13,9,4 in bits 7:5 and id 0 in the rest. Mask register 2 (set 0x110, no clear address) holds only id 0. Priority register 0 (0x120) holds ids 1,2,6,10 from nibble 3 down to nibble 0. Priority register 1 (0x124) holds 7,8,9,0. Group 12 contains ids 3 and 4. Group 13 contains ids 5, 6, 7 and 10. Ids 1 to 9 have a vector.
- R7: Only fields whose enabling state changes on a write adjust a count. Rewriting the same value, or moving a priority field from one nonzero value to another, leaves the outputs unchanged.
- R8: `src_en[s]` is 1 exactly when source s has a vector, is named in at least one place, and every mask bit, priority field and group entry that names it is enabling. The output updates in the cycle after the write.
- R9: Id 0 is reserved. An id that has no vector and is not a group is ignored. Changing either one alters no `src_en` bit, and those ids' own `src_en` bits stay 0.
- R10: A change of a field that names a group applies the same increment or decrement to every vectored member of that group.
- R11: After reset all registers read 0 and `src_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| addr | input | 32 | Register address, bits 28:0 decoded |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| src_en | output | N_ID | Per-id enable, bit s for id s |

## Verification
Directed writes walk a single source through each stage. First one of its two conditions holds and the output stays low. Then both hold and the output rises. A nonzero-to-nonzero rewrite follows, and then a clear. This separates counting on change from counting on every write. Group writes that enable two members at once show whether fan-out reaches all members. Writes to reserved and vector-less ids, to the read-only mask register and to aliases with bits 31:29 set check that decode and filtering leave state untouched. A long random mix of set, clear, overwrite and read traffic with sparse data is then compared against an all-conditions-hold model, which exposes any drift in the counters.

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl #(
  parameter int N_ID   = 16,
  parameter int IDW    = 4,
  parameter int N_MREG = 3,
  parameter int MREG_W = 8,
  parameter int N_PREG = 2,
  parameter int PREG_W = 16,
  parameter int FLD_W  = 4,
  parameter int N_GRP  = 2,
  parameter logic [N_ID-1:0]                         HAS_VEC   = 16'h03FE,
  parameter logic [N_GRP*IDW-1:0]                    GRP_ID    = 8'hDC,
  parameter logic [N_GRP*N_ID-1:0]                   GRP_MEM   = 32'h04E0_0018,
  parameter logic [N_MREG*MREG_W*IDW-1:0]            MMAP      = 96'h00000000_D9400000_123C0B85,
  parameter logic [N_PREG*(PREG_W/FLD_W)*IDW-1:0]    PMAP      = 32'h7890_126A,
  parameter logic [N_MREG*32-1:0]                    MSET_ADDR = 96'h00000110_00000108_00000100,
  parameter logic [N_MREG*32-1:0]                    MCLR_ADDR = 96'h00000000_0000010C_00000104,
  parameter logic [N_PREG*32-1:0]                    PSET_ADDR = 64'h00000124_00000120
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [31:0]     addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic [N_ID-1:0] src_en
);
  localparam int NFLD = PREG_W / FLD_W;
  localparam int NTOT = N_MREG * MREG_W + N_PREG * NFLD;
  localparam int CW   = $clog2(NTOT + 1) + 1;

  function automatic logic [IDW-1:0] mid(int r, int b);
    return MMAP[(r*MREG_W + b)*IDW +: IDW];
  endfunction

  function automatic logic [IDW-1:0] pid(int p, int f);
    return PMAP[(p*NFLD + f)*IDW +: IDW];
  endfunction

  function automatic logic [IDW-1:0] gid(int g);
    return GRP_ID[g*IDW +: IDW];
  endfunction

  function automatic int occ(int id);
    int n;
    n = 0;
    for (int r = 0; r < N_MREG; r++)
      for (int b = 0; b < MREG_W; b++)
        if (int'(mid(r, b)) == id) n++;
    for (int p = 0; p < N_PREG; p++)
      for (int f = 0; f < NFLD; f++)
        if (int'(pid(p, f)) == id) n++;
    return n;
  endfunction

  function automatic logic [CW-1:0] need(int s);
    int n;
    if (s == 0 || !HAS_VEC[s]) return '0;
    n = occ(s);
    for (int g = 0; g < N_GRP; g++)
      if (GRP_MEM[g*N_ID + s]) n += occ(int'(gid(g)));
    return CW'(n);
  endfunction

  function automatic logic hit(logic [31:0] cfg, logic [31:0] a);
    return (cfg[28:0] != 29'd0) && (a[28:0] == cfg[28:0]);
  endfunction

  logic [MREG_W-1:0] mreg_q [N_MREG];
  logic [MREG_W-1:0] mreg_d [N_MREG];
  logic [PREG_W-1:0] preg_q [N_PREG];
  logic [PREG_W-1:0] preg_d [N_PREG];
  logic [CW-1:0]     cnt_q  [N_ID];
  logic [CW-1:0]     cnt_d  [N_ID];
  logic [N_MREG-1:0] hit_ms, hit_mc;
  logic [N_PREG-1:0] hit_p;
  logic [N_ID-1:0]   en_d;
  logic [31:0]       rd_mux;
  int                dlt [N_ID];

  logic unused_bits;
  assign unused_bits = ^{addr[31:29], wdata[31:PREG_W]};

  always_comb begin
    for (int r = 0; r < N_MREG; r++) begin
      hit_ms[r] = hit(MSET_ADDR[r*32 +: 32], addr);
      hit_mc[r] = hit(MCLR_ADDR[r*32 +: 32], addr);
    end
    for (int p = 0; p < N_PREG; p++)
      hit_p[p] = hit(PSET_ADDR[p*32 +: 32], addr);
  end

  always_comb begin
    for (int r = 0; r < N_MREG; r++) begin
      mreg_d[r] = mreg_q[r];
      if (wr_en && hit_ms[r] && MCLR_ADDR[r*32 +: 29] != 29'd0)
        mreg_d[r] = mreg_q[r] | wdata[MREG_W-1:0];
      if (wr_en && hit_mc[r])
        mreg_d[r] = mreg_q[r] & ~wdata[MREG_W-1:0];
    end
    for (int p = 0; p < N_PREG; p++)
      preg_d[p] = (wr_en && hit_p[p]) ? wdata[PREG_W-1:0] : preg_q[p];
  end

  always_comb begin : count_next
    logic was, now;
    int   tot;
    for (int i = 0; i < N_ID; i++) dlt[i] = 0;
    for (int r = 0; r < N_MREG; r++)
      for (int b = 0; b < MREG_W; b++)
        if (mreg_d[r][b] != mreg_q[r][b])
          dlt[mid(r, b)] += mreg_d[r][b] ? 1 : -1;
    for (int p = 0; p < N_PREG; p++)
      for (int f = 0; f < NFLD; f++) begin
        was = preg_q[p][f*FLD_W +: FLD_W] != '0;
        now = preg_d[p][f*FLD_W +: FLD_W] != '0;
        if (was != now) dlt[pid(p, f)] += now ? 1 : -1;
      end
    for (int s = 0; s < N_ID; s++) begin
      tot = 0;
      if (s != 0 && HAS_VEC[s]) begin
        tot = dlt[s];
        for (int g = 0; g < N_GRP; g++)
          if (GRP_MEM[g*N_ID + s]) tot += dlt[gid(g)];
      end
      cnt_d[s] = cnt_q[s] + CW'(tot);
      en_d[s]  = (s != 0) && HAS_VEC[s] && need(s) != '0 && cnt_d[s] == need(s);
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int r = 0; r < N_MREG; r++)
      if (hit_ms[r] || hit_mc[r]) rd_mux = 32'(mreg_q[r]);
    for (int p = 0; p < N_PREG; p++)
      if (hit_p[p]) rd_mux = 32'(preg_q[p]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < N_MREG; r++) mreg_q[r] <= '0;
      for (int p = 0; p < N_PREG; p++) preg_q[p] <= '0;
      for (int s = 0; s < N_ID; s++)   cnt_q[s]  <= '0;
      src_en <= '0;
      rdata  <= '0;
    end else begin
      mreg_q <= mreg_d;
      preg_q <= preg_d;
      cnt_q  <= cnt_d;
      src_en <= en_d;
      if (rd_en) rdata <= rd_mux;
    end
  end

  // Guards on register write semantics
  for (genvar gr = 0; gr < N_MREG; gr++) begin : g_mchk
    if (MCLR_ADDR[gr*32 +: 29] != 29'd0) begin : g_pair
      a_r2_set_ors: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_ms[gr] && !hit_mc[gr]) |=>
          ((mreg_q[gr] & $past(wdata[MREG_W-1:0])) == $past(wdata[MREG_W-1:0])));
      a_r3_clr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_mc[gr]) |=> ((mreg_q[gr] & $past(wdata[MREG_W-1:0])) == '0));
    end else begin : g_ro
      a_r4_ro_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_ms[gr]) |=> $stable(mreg_q[gr]));
    end
  end

  for (genvar gp = 0; gp < N_PREG; gp++) begin : g_pchk
    a_r4_prio_replace: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_p[gp]) |=> (preg_q[gp] == $past(wdata[PREG_W-1:0])));
  end

  // Guards on enable counting
  for (genvar gs = 0; gs < N_ID; gs++) begin : g_schk
    a_r8_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[gs] <= need(gs));
    a_r8_en_full: assert property (@(posedge clk) disable iff (!rst_n)
      src_en[gs] |-> (cnt_q[gs] == need(gs) && need(gs) != '0));
  end

  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(src_en));
endmodule

// File: tb/irq_enable_ctrl_tb.sv
`timescale 1ns/1ps
module irq_enable_ctrl_tb;
  localparam logic [15:0]  HAS_VEC   = 16'h03FE;
  localparam logic [7:0]   GRP_ID    = 8'hDC;
  localparam logic [31:0]  GRP_MEM   = 32'h04E0_0018;
  localparam logic [95:0]  MMAP      = 96'h00000000_D9400000_123C0B85;
  localparam logic [31:0]  PMAP      = 32'h7890_126A;
  localparam logic [95:0]  MSET_ADDR = 96'h00000110_00000108_00000100;
  localparam logic [95:0]  MCLR_ADDR = 96'h00000000_0000010C_00000104;
  localparam logic [63:0]  PSET_ADDR = 64'h00000124_00000120;

  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [31:0] addr = 0, wdata = 0;
  wire  [31:0] rdata;
  wire  [15:0] src_en;

  irq_enable_ctrl #(
    .HAS_VEC(HAS_VEC), .GRP_ID(GRP_ID), .GRP_MEM(GRP_MEM), .MMAP(MMAP), .PMAP(PMAP),
    .MSET_ADDR(MSET_ADDR), .MCLR_ADDR(MCLR_ADDR), .PSET_ADDR(PSET_ADDR)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_en(src_en)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0]  mm [3];
  logic [15:0] pp [2];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic match(logic [31:0] cfg, logic [31:0] a);
    return cfg[28:0] != 0 && a[28:0] == cfg[28:0];
  endfunction

  function automatic logic [31:0] model_read(logic [31:0] a);
    logic [31:0] v = 0;
    for (int r = 0; r < 3; r++)
      if (match(MSET_ADDR[r*32 +: 32], a) || match(MCLR_ADDR[r*32 +: 32], a)) v = {24'h0, mm[r]};
    for (int p = 0; p < 2; p++)
      if (match(PSET_ADDR[p*32 +: 32], a)) v = {16'h0, pp[p]};
    return v;
  endfunction

  function automatic logic in_grp(int id, int s);
    for (int g = 0; g < 2; g++)
      if (int'(GRP_ID[g*4 +: 4]) == id && GRP_MEM[g*16 + s]) return 1;
    return 0;
  endfunction

  function automatic logic [15:0] exp_en();
    logic [15:0] e = 0;
    for (int s = 1; s < 16; s++) begin
      logic ok = 1;
      int   n  = 0;
      if (!HAS_VEC[s]) continue;
      for (int r = 0; r < 3; r++)
        for (int b = 0; b < 8; b++) begin
          int id = int'(MMAP[(r*8 + b)*4 +: 4]);
          if (id == s || in_grp(id, s)) begin n++; ok &= mm[r][b]; end
        end
      for (int p = 0; p < 2; p++)
        for (int f = 0; f < 4; f++) begin
          int id = int'(PMAP[(p*4 + f)*4 +: 4]);
          if (id == s || in_grp(id, s)) begin n++; ok &= (pp[p][f*4 +: 4] != 0); end
        end
      e[s] = ok && n > 0;
    end
    return e;
  endfunction

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    for (int r = 0; r < 3; r++) begin
      if (match(MSET_ADDR[r*32 +: 32], a) && MCLR_ADDR[r*32 +: 29] != 0) mm[r] = mm[r] | d[7:0];
      if (match(MCLR_ADDR[r*32 +: 32], a)) mm[r] = mm[r] & ~d[7:0];
    end
    for (int p = 0; p < 2; p++)
      if (match(PSET_ADDR[p*32 +: 32], a)) pp[p] = d[15:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [31:0] a, string tag);
    logic [31:0] e;
    @(negedge clk);
    rd_en = 1; addr = a; e = model_read(a);
    @(negedge clk);
    rd_en = 0;
    chk(tag, rdata, e);
  endtask

  task automatic chk_en(string tag);
    chk(tag, {16'h0, src_en}, {16'h0, exp_en()});
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [31:0] ALST [8] = '{32'h100, 32'h104, 32'h108, 32'h10C,
                                       32'h110, 32'h120, 32'h124, 32'h200};

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < 3; r++) mm[r] = 0;
    for (int p = 0; p < 2; p++) pp[p] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk("R11 reset src_en", {16'h0, src_en}, 32'h0);
    rd(32'h100, "R11 reset mask0");
    rd(32'h124, "R11 reset prio1");

    wr(32'hE000_0100, 32'h80);
    rd(32'h100, "R1 R2 high bits ignored, set alias");
    chk("R8 one of two conditions", {16'h0, src_en}, 32'h0);

    wr(32'h120, 32'h1000);
    chk("R6 R8 id1 enabled", {16'h0, src_en}, 32'h0002);
    wr(32'h120, 32'h3000);
    chk("R7 nonzero to nonzero", {16'h0, src_en}, 32'h0002);
    wr(32'h100, 32'h80);
    chk("R7 rewrite same bit", {16'h0, src_en}, 32'h0002);

    wr(32'h2000_0104, 32'h80);
    chk("R3 clear alias disables id1", {16'h0, src_en}, 32'h0);
    rd(32'h104, "R3 R5 read via clear alias");

    wr(32'h100, 32'h30);
    wr(32'h108, 32'h20);
    chk("R10 group enables ids 3 and 4", {16'h0, src_en}, 32'h0018);
    wr(32'h104, 32'h10);
    chk("R10 group clear disables both", {16'h0, src_en}, 32'h0);

    wr(32'h100, 32'h0C);
    chk("R9 reserved and vectorless ids", {16'h0, src_en}, 32'h0);
    rd(32'h100, "R9 bits still stored");
    wr(32'h120, 32'h300F);
    chk("R9 vectorless group member", {16'h0, src_en}, 32'h0);

    wr(32'h110, 32'hFF);
    rd(32'h110, "R4 read-only mask register");
    wr(32'h124, 32'hFFFF_ABCD);
    rd(32'h124, "R4 R5 prio replace zero-extended");
    wr(32'h200, 32'hFFFF_FFFF);
    rd(32'h200, "R1 unmapped read");
    rd(32'h100, "R1 unmapped write no effect");
    chk_en("R1 unmapped write outputs");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] a = ALST[$urandom_range(0, 7)] | ({$urandom_range(0, 7)} << 29);
      logic [31:0] d = $urandom & $urandom;
      if ($urandom_range(0, 3) == 0) rd(a, "R5 random read");
      else begin
        wr(a, d);
        chk_en("R8 random enable vector");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule